// File: doc/BRIEF.md
# Vector Condition Fail-First Truncation Unit

This block walks through the elements of a vectorised condition-register operation, one element per accepted cycle, and shortens the vector length the first time a data-dependent condition test fails. For each element it receives the operation's result, either a four-bit condition field (field-operand mode) or a single condition bit (bit-operand mode). It picks the bit to test, compares it with an invert control and either lets the element store or stops the walk.

A run begins with a start strobe. The strobe carries the vector length and a five-bit mode word, and both are captured only when the unit is idle. While the run is busy, the unit shows the index of the element it expects next. A passing element raises a store enable in the same cycle. When the walk ends, either on the first failure or after the last element, `done_o` pulses for one cycle and `vl_o` holds the resulting vector length until the next run ends. An include/exclude choice in the mode word decides whether a failing element counts in the new length.

Top module: `cff_trunc_unit`

## Requirements
- R1: During and after synchronous active-low reset, `busy_o`, `done_o`, `store_en_o`, `vl_o` and `elem_idx_o` are all 0.
- R2: Suppose `start_i` is high at a clock edge while the unit is idle. With `vl_i` > 0, `busy_o` is 1 after that edge and `elem_idx_o` is 0. With `vl_i` = 0, `done_o` is 1 for the next cycle and `vl_o` becomes 0.
- R3: When `op5_i` was 1 at start (bit-operand mode), the tested bit is `elem_bit_i`, and `elem_field_i` has no effect.
- R4: When `op5_i` was 0 at start (field-operand mode), the selector `mode_i[1:0]` picks the tested field bit. 0 picks `elem_field_i[3]` (LT), 1 picks `[2]` (GT), 2 picks `[1]` (EQ) and 3 picks `[0]` (SO).
- R5: With fail-first enabled, an accepted element passes when its tested bit equals the invert control `mode_i[2]`. A passing element raises `store_en_o` in the same cycle and advances `elem_idx_o` by one. A failing element raises no store enable.
- R6: When `mode_i[4:3]` = 2'b01 (exclusive variant), the first failure at index k makes `vl_o` = k.
- R7: When `mode_i[4:3]` = 2'b10 (inclusive variant), the first failure at index k makes `vl_o` = k+1.
- R8: If every element up to index VL-1 passes, the run ends after that last element, and `vl_o` equals the VL captured at start.
- R9: The cycle after the ending element, `busy_o` is 0 and `done_o` is 1 for exactly one cycle. Elements offered after the run ends raise no store enable.
- R10: A start strobe while `busy_o` is 1 is ignored. The run keeps its index, its captured VL and its mode.
- R11: When `mode_i[4:3]` is 2'b00 or 2'b11, no test is made. Every element stores, and `vl_o` equals the captured VL.
- R12: `store_en_o` is never 1 unless `busy_o` and `elem_valid_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| vl_i | input | VL_W | Vector length for the run |
| mode_i | input | 5 | [4:3] variant, [2] invert control, [1:0] field-bit selector |
| op5_i | input | 1 | 1 = bit-operand mode, 0 = field-operand mode |
| elem_valid_i | input | 1 | An element result is offered this cycle |
| elem_field_i | input | 4 | Four-bit condition field result |
| elem_bit_i | input | 1 | Single condition bit result |
| busy_o | output | 1 | A run is in progress |
| elem_idx_o | output | VL_W | Index of the element expected next |
| store_en_o | output | 1 | Offered element passes and may be stored |
| vl_o | output | VL_W | Resulting vector length of the last run |
| done_o | output | 1 | One-cycle pulse when a run ends |

## Verification
Several properties are checked on every cycle: store enables occur only inside a busy run with an offered element, the end of a run always coincides with the done pulse, the expected index stays below the captured length, and neither the resulting length nor the number of stores exceeds that captured length. Other behaviour can only be shown by the bench's scenarios, because it depends on the data: which bit is tested in each operand mode and selector, the exact truncation point for the exclusive and inclusive variants, the disabled variants, and whether a start strobe in mid-run is really ignored.

// File: rtl/cff_pkg.sv
// Package: shared types for the fail-first truncation unit.
// Assumes the five-bit mode word layout described in the brief.
package cff_pkg;

    // Fail-first variant carried in the top two mode bits
    typedef enum logic [1:0] {
        FF_NONE = 2'b00,
        FF_EXCL = 2'b01,
        FF_INCL = 2'b10,
        FF_RSVD = 2'b11
    } ff_kind_e;

    // Decoded run configuration, captured at start
    typedef struct packed {
        ff_kind_e   kind;
        logic       inv;
        logic [1:0] sel;
        logic       op5;
    } ff_cfg_t;

    localparam int unsigned FIELD_W = 4;

endpackage

// File: rtl/cff_mode_decode.sv
// Module: cff_mode_decode
// Splits the raw mode word and operand-mode flag into a configuration
// struct. Purely combinational; assumes mode bits are stable at start.
module cff_mode_decode
    import cff_pkg::*;
(
    input  logic [4:0] mode_i,
    input  logic       op5_i,
    output ff_cfg_t    cfg_o,
    output logic       test_en_o
);

    // Unpack the fields into the configuration struct
    always_comb begin
        cfg_o.kind = ff_kind_e'(mode_i[4:3]);
        cfg_o.inv  = mode_i[2];
        cfg_o.sel  = mode_i[1:0];
        cfg_o.op5  = op5_i;
    end

    // Only the two defined variants enable the condition test
    always_comb begin
        unique case (ff_kind_e'(mode_i[4:3]))
            FF_EXCL, FF_INCL: test_en_o = 1'b1;
            default:          test_en_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cff_test_eval.sv
// Module: cff_test_eval
// Picks the bit to test from the element result and compares it with the
// invert control. Combinational. Field bit order: [3]=LT ... [0]=SO, so
// selector value s reads field bit (FIELD_W-1-s).
module cff_test_eval
    import cff_pkg::*;
#(
    parameter int unsigned FW = FIELD_W
) (
    input  ff_cfg_t         cfg_i,
    input  logic            test_en_i,
    input  logic [FW-1:0]   field_i,
    input  logic            bit_i,
    output logic            pass_o
);

    localparam int unsigned SEL_W = $clog2(FW);

    logic [FW-1:0] ordered;
    logic          tested;

    // Reverse the field so the selector indexes it directly
    genvar g;
    generate
        for (g = 0; g < int'(FW); g++) begin : g_order
            assign ordered[g] = field_i[FW-1-g];
        end
    endgenerate

    // Choose between the single produced bit and the selected field bit
    always_comb begin
        if (cfg_i.op5) begin
            tested = bit_i;
        end else begin
            tested = ordered[cfg_i.sel[SEL_W-1:0]];
        end
    end

    // Pass when the tested bit matches the invert control, or when testing is off
    always_comb begin
        if (!test_en_i) begin
            pass_o = 1'b1;
        end else begin
            pass_o = (tested == cfg_i.inv);
        end
    end

endmodule

// File: rtl/cff_seq.sv
// Module: cff_seq
// Run sequencer: captures length and configuration on an idle start,
// steps the element index on each passing element, and ends the run on
// the first failure or after the last element. Assumes pass_i is valid
// whenever elem_valid_i is high during a run.
module cff_seq
    import cff_pkg::*;
#(
    parameter int unsigned VL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [VL_W-1:0] vl_i,
    input  ff_cfg_t         cfg_d_i,
    input  logic            test_en_d_i,
    input  logic            elem_valid_i,
    input  logic            pass_i,
    output ff_cfg_t         cfg_q_o,
    output logic            test_en_q_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [VL_W-1:0] vl_o,
    output logic [VL_W-1:0] idx_o,
    output logic            store_en_o
);

    localparam logic [VL_W-1:0] ONE = VL_W'(1);

    logic [VL_W-1:0] vl_q;
    logic [VL_W-1:0] idx_q;
    logic [VL_W-1:0] idx_nxt;
    logic            busy_q;
    logic            accept;
    logic            is_last;
    logic            fail;
    logic            start_ok;

    // Derived strobes for this cycle
    always_comb begin
        accept   = busy_q && elem_valid_i;
        idx_nxt  = idx_q + ONE;
        is_last  = (idx_nxt == vl_q);
        fail     = accept && !pass_i;
        start_ok = start_i && !busy_q;
    end

    // Run state: busy flag, index and captured length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            vl_q   <= '0;
        end else if (start_ok) begin
            busy_q <= (vl_i != '0);
            idx_q  <= '0;
            vl_q   <= vl_i;
        end else if (fail) begin
            busy_q <= 1'b0;
        end else if (accept) begin
            if (is_last) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_nxt;
            end
        end
    end

    // Configuration captured at an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q_o     <= '0;
            test_en_q_o <= 1'b0;
        end else if (start_ok) begin
            cfg_q_o     <= cfg_d_i;
            test_en_q_o <= test_en_d_i;
        end
    end

    // Result length and one-cycle done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            vl_o   <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_ok && (vl_i == '0)) begin
                done_o <= 1'b1;
                vl_o   <= '0;
            end else if (fail) begin
                done_o <= 1'b1;
                vl_o   <= (cfg_q_o.kind == FF_INCL) ? idx_nxt : idx_q;
            end else if (accept && is_last) begin
                done_o <= 1'b1;
                vl_o   <= vl_q;
            end
        end
    end

    // Outputs visible to the element stream
    always_comb begin
        busy_o     = busy_q;
        idx_o      = idx_q;
        store_en_o = accept && pass_i;
    end

endmodule

// File: rtl/cff_trunc_unit.sv
// Module: cff_trunc_unit
// Top of the fail-first truncation unit: decodes the mode word, evaluates
// each element's condition test against the captured configuration and
// sequences the run. One element may be accepted per cycle.
module cff_trunc_unit
    import cff_pkg::*;
#(
    parameter int unsigned VL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [VL_W-1:0] vl_i,
    input  logic [4:0]      mode_i,
    input  logic            op5_i,
    input  logic            elem_valid_i,
    input  logic [3:0]      elem_field_i,
    input  logic            elem_bit_i,
    output logic            busy_o,
    output logic [VL_W-1:0] elem_idx_o,
    output logic            store_en_o,
    output logic [VL_W-1:0] vl_o,
    output logic            done_o
);

    ff_cfg_t cfg_d;
    ff_cfg_t cfg_q;
    logic    test_en_d;
    logic    test_en_q;
    logic    pass;

    // Decode the raw mode word
    cff_mode_decode u_dec (
        .mode_i    (mode_i),
        .op5_i     (op5_i),
        .cfg_o     (cfg_d),
        .test_en_o (test_en_d)
    );

    // Evaluate the condition test with the captured configuration
    cff_test_eval #(.FW(FIELD_W)) u_eval (
        .cfg_i     (cfg_q),
        .test_en_i (test_en_q),
        .field_i   (elem_field_i),
        .bit_i     (elem_bit_i),
        .pass_o    (pass)
    );

    // Sequence the run
    cff_seq #(.VL_W(VL_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .vl_i         (vl_i),
        .cfg_d_i      (cfg_d),
        .test_en_d_i  (test_en_d),
        .elem_valid_i (elem_valid_i),
        .pass_i       (pass),
        .cfg_q_o      (cfg_q),
        .test_en_q_o  (test_en_q),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .vl_o         (vl_o),
        .idx_o        (elem_idx_o),
        .store_en_o   (store_en_o)
    );

endmodule

// File: rtl/cff_trunc_unit_chk.sv
// Module: cff_trunc_unit_chk
// Property checker bound to the top. Keeps its own record of the length
// captured at start and of the stores made in the current run.
module cff_trunc_unit_chk #(
    parameter int unsigned VL_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [VL_W-1:0] vl_i,
    input logic            elem_valid_i,
    input logic            busy_o,
    input logic [VL_W-1:0] elem_idx_o,
    input logic            store_en_o,
    input logic [VL_W-1:0] vl_o,
    input logic            done_o
);

    logic [VL_W-1:0] shadow_vl;
    logic [VL_W:0]   store_cnt;

    // Track the accepted length and count stores within a run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_vl <= '0;
            store_cnt <= '0;
        end else if (start_i && !busy_o) begin
            shadow_vl <= vl_i;
            store_cnt <= '0;
        end else if (store_en_o) begin
            store_cnt <= store_cnt + 1'b1;
        end
    end

    // R12
    store_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_en_o |-> (busy_o && elem_valid_i));

    // R9
    end_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6
    vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (vl_o <= shadow_vl));

    // R5
    store_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (store_cnt <= {1'b0, vl_o}));

    // R8
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (elem_idx_o < shadow_vl));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !elem_valid_i) |=> (busy_o && $stable(vl_o) && $stable(elem_idx_o)));

endmodule

bind cff_trunc_unit cff_trunc_unit_chk #(.VL_W(VL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .vl_i         (vl_i),
    .elem_valid_i (elem_valid_i),
    .busy_o       (busy_o),
    .elem_idx_o   (elem_idx_o),
    .store_en_o   (store_en_o),
    .vl_o         (vl_o),
    .done_o       (done_o)
);

// File: tb/cff_trunc_unit_test.sv
// Bench: directed corners plus seeded random runs, each compared with a
// model computed from the requirements.
module cff_trunc_unit_test;

    localparam int unsigned VL_W = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [VL_W-1:0] vl_i = '0;
    logic [4:0]      mode_i = '0;
    logic            op5_i = 1'b0;
    logic            elem_valid_i = 1'b0;
    logic [3:0]      elem_field_i = '0;
    logic            elem_bit_i = 1'b0;
    logic            busy_o;
    logic [VL_W-1:0] elem_idx_o;
    logic            store_en_o;
    logic [VL_W-1:0] vl_o;
    logic            done_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [3:0] fld [0:15];
    logic       bt  [0:15];

    always #5 clk = ~clk;

    cff_trunc_unit #(.VL_W(VL_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .mode_i(mode_i), .op5_i(op5_i), .elem_valid_i(elem_valid_i),
        .elem_field_i(elem_field_i), .elem_bit_i(elem_bit_i),
        .busy_o(busy_o), .elem_idx_o(elem_idx_o), .store_en_o(store_en_o),
        .vl_o(vl_o), .done_o(done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit ff_on(input logic [4:0] m);
        return (m[4:3] == 2'b01) || (m[4:3] == 2'b10);
    endfunction

    // Model of R3, R4, R5 and R11
    function automatic bit exp_pass(input logic [4:0] m, input bit op5,
                                    input logic [3:0] f, input bit b);
        bit t;
        if (!ff_on(m)) return 1'b1;
        t = op5 ? b : f[3 - m[1:0]];
        return t == m[2];
    endfunction

    // One run: start, feed elements, check stores, result and done pulse
    task automatic run(input int vl, input logic [4:0] m, input bit op5, input bit gap);
        int exp_vl;
        string tag;
        tag = op5 ? "R3/R5" : "R4/R5";
        @(negedge clk);
        start_i = 1'b1; vl_i = VL_W'(vl); mode_i = m; op5_i = op5;
        @(negedge clk);
        start_i = 1'b0;
        if (vl == 0) begin
            chk("R2 empty done", int'(done_o), 1);
            chk("R2 empty vl", int'(vl_o), 0);
            @(negedge clk);
            chk("R9 done one cycle", int'(done_o), 0);
            return;
        end
        chk("R2 busy", int'(busy_o), 1);
        chk("R2 idx", int'(elem_idx_o), 0);
        if (gap) begin
            // R10: a start strobe in mid-run with a different length and mode
            start_i = 1'b1; vl_i = VL_W'(vl + 3); mode_i = ~m; op5_i = ~op5;
            @(negedge clk);
            start_i = 1'b0; vl_i = '0; mode_i = '0; op5_i = 1'b0;
            chk("R10 busy kept", int'(busy_o), 1);
            chk("R10 idx kept", int'(elem_idx_o), 0);
        end
        exp_vl = vl;
        for (int i = 0; i < vl; i++) begin
            bit p;
            elem_valid_i = 1'b1; elem_field_i = fld[i]; elem_bit_i = bt[i];
            p = exp_pass(m, op5, fld[i], bt[i]);
            #1;
            chk({tag, " store"}, int'(store_en_o), int'(p));
            chk("R5 idx", int'(elem_idx_o), i);
            @(negedge clk);
            if (!p) begin
                exp_vl = (m[4:3] == 2'b10) ? i + 1 : i;
                break;
            end
        end
        elem_valid_i = 1'b1;
        chk("R9 done", int'(done_o), 1);
        chk("R9 busy low", int'(busy_o), 0);
        if (!ff_on(m)) chk("R11 vl", int'(vl_o), exp_vl);
        else if (exp_vl == vl) chk("R8 vl", int'(vl_o), exp_vl);
        else if (m[4:3] == 2'b10) chk("R7 vl", int'(vl_o), exp_vl);
        else chk("R6 vl", int'(vl_o), exp_vl);
        #1;
        chk("R9 no store after end", int'(store_en_o), 0);
        @(negedge clk);
        elem_valid_i = 1'b0;
        chk("R9 done one cycle", int'(done_o), 0);
    endtask

    // Fill data so each element passes except possibly at fail_at
    task automatic fill(input logic [4:0] m, input bit op5, input int fail_at);
        for (int i = 0; i < 16; i++) begin
            fld[i] = 4'($urandom);
            bt[i]  = 1'($urandom);
            if (ff_on(m) && (exp_pass(m, op5, fld[i], bt[i]) != (i != fail_at))) begin
                if (op5) bt[i] = ~bt[i];
                else fld[i][3 - m[1:0]] = ~fld[i][3 - m[1:0]];
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 store", int'(store_en_o), 0);
        chk("R1 vl", int'(vl_o), 0);
        chk("R1 idx", int'(elem_idx_o), 0);
        rst_n = 1'b1;

        // Directed corners
        run(0, 5'b01_0_00, 1'b0, 1'b0);
        fill(5'b01_1_00, 1'b1, 2);  run(6, 5'b01_1_00, 1'b1, 1'b0);   // R6 bit mode
        fill(5'b10_0_10, 1'b0, 0);  run(5, 5'b10_0_10, 1'b0, 1'b0);   // R7 index 0
        fill(5'b10_1_11, 1'b0, 99); run(4, 5'b10_1_11, 1'b0, 1'b1);   // R8, R10
        fill(5'b01_0_01, 1'b0, 3);  run(4, 5'b01_0_01, 1'b0, 1'b0);   // R4 last fails
        fill(5'b00_0_00, 1'b0, 99); run(5, 5'b00_1_10, 1'b0, 1'b0);   // R11
        fill(5'b11_0_00, 1'b1, 99); run(3, 5'b11_0_00, 1'b1, 1'b1);   // R11
        fill(5'b10_1_00, 1'b1, 0);  run(1, 5'b10_1_00, 1'b1, 1'b0);   // R7 single

        // Seeded random runs
        for (int r = 0; r < 60; r++) begin
            logic [4:0] m;
            bit o;
            int v;
            int fa;
            m  = 5'($urandom);
            o  = 1'($urandom);
            v  = $urandom_range(0, 12);
            fa = $urandom_range(0, 20);
            fill(m, o, fa);
            run(v, m, o, 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule